// File: doc/BRIEF.md
# Receive Queue Status Flags

This block derives the status flags of a receive queue whose entries may carry an end-of-frame mark. The queue storage sits elsewhere. The block samples the queue's occupancy count and the number of stored end-of-frame marks. It also takes strobes that report a newly arrived frame end and individual receive errors.

From these inputs it produces five outputs:
- a fill flag with hysteresis between a programmable threshold and a lower drain level
- a data-ready flag
- an end-of-frame flag that only framed link modes use
- a summary error flag
- an interrupt/request line

Software clears the sticky parts of the status with a status-read strobe. Every flag is registered. Each output reflects the inputs sampled at the preceding rising clock edge, and all flags reset to zero.

Top module: `rxq_status_flags`

## Requirements
- R1: During reset and on the first cycle after it, every output (full, ready, end-of-frame, error, interrupt) is 0.
- R2: The full flag becomes 1 one cycle after the occupancy is strictly greater than the threshold. An occupancy equal to the threshold does not set it.
- R3: Once set, the full flag stays 1 while the occupancy is greater than or equal to the drain level. It clears one cycle after the occupancy drops below the drain level.
- R4: The ready flag is 1 one cycle after the occupancy is nonzero, and 0 one cycle after it is zero.
- R5: In framed modes (`link_mode` 2 or 3), the end-of-frame flag is 1 one cycle after the stored end-of-frame count is nonzero.
- R6: In framed modes, an `eof_strobe` pulse sets a sticky end-of-frame bit. A status read clears it unless an `eof_strobe` or an error strobe arrives in the same cycle. The flag then drops one cycle after the read if no end-of-frame mark is stored.
- R7: In framed modes, any error strobe sets the sticky end-of-frame bit, even when no frame end was received.
- R8: In unframed modes (`link_mode` 0 or 1), the end-of-frame flag reads 0 whatever the frame-end inputs are. Frame-end events seen in those modes leave no sticky state behind.
- R9: Each error strobe bit sets its own sticky error bit. The error flag is the OR of those bits. A status read clears every bit except one whose strobe is active in the same cycle.
- R10: The interrupt line equals full OR (end-of-frame AND enable), where the enable is sampled one cycle earlier. With the enable at 0, it follows the full flag. With the enable at 1, a set end-of-frame flag raises it below the threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| occ_cnt | input | OCC_W | Current number of entries in the queue |
| thr_lvl | input | OCC_W | Fill threshold (full sets above it) |
| gran_lvl | input | OCC_W | Drain level (full clears below it) |
| eof_strobe | input | 1 | One-cycle pulse: a frame end was received |
| eof_stored | input | OCC_W | Number of end-of-frame marks held in the queue |
| err_strobe | input | NUM_ERR | One-cycle pulses, one per error source |
| stat_rd | input | 1 | Status-read pulse; clears sticky bits |
| link_mode | input | 2 | 0, 1 unframed; 2, 3 framed |
| eof_irq_en | input | 1 | Lets the end-of-frame flag raise the interrupt |
| full_flag | output | 1 | Fill flag with hysteresis |
| ready_flag | output | 1 | Queue holds at least one entry |
| eof_flag | output | 1 | End-of-frame status (framed modes only) |
| err_flag | output | 1 | OR of sticky error bits |
| irq_req | output | 1 | Interrupt/request line |

## Verification
A wrong hysteresis state appears on `full_flag` and `irq_req` in the cycle after the occupancy passes through the band between the drain level and the threshold. The bench therefore parks the occupancy exactly on both edges of that band. A sticky end-of-frame or error bit that clears too early or too late shows up on the flag one cycle after the status read. The directed sequences read status with and without a same-cycle strobe, with and without stored marks. Leaking sticky state from an unframed mode becomes visible as soon as the mode returns to framed with no mark stored.

// File: rtl/rxq_status_pkg.sv
package rxq_status_pkg;

    typedef enum logic [1:0] {
        LM_ASYNC      = 2'd0,
        LM_IR_SLOW    = 2'd1,
        LM_FRAME_MED  = 2'd2,
        LM_FRAME_FAST = 2'd3
    } link_mode_t;

    function automatic logic is_framed(input link_mode_t m);
        return (m == LM_FRAME_MED) || (m == LM_FRAME_FAST);
    endfunction

endpackage

// File: rtl/rxq_fill_hyst.sv
module rxq_fill_hyst #(
    parameter int OCC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] occ,
    input  logic [OCC_W-1:0] thr,
    input  logic [OCC_W-1:0] gran,
    output logic             full_o,
    output logic             ready_o
);

    typedef struct packed {
        logic full;
        logic ready;
    } fill_st_t;

    fill_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.full) begin
            st_d.full = !(occ < gran);
        end else begin
            st_d.full = (occ > thr);
        end
        st_d.ready = (occ != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_o  = st_q.full;
    assign ready_o = st_q.ready;

    assert_full_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ > thr) |=> full_o);

    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !(occ < gran)) |=> full_o);

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && (occ < gran)) |=> !full_o);

    assert_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |=> !ready_o);

endmodule

// File: rtl/rxq_frame_end.sv
module rxq_frame_end #(
    parameter int OCC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             framed,
    input  logic             eof_in,
    input  logic [OCC_W-1:0] eof_cnt,
    input  logic             err_any,
    input  logic             stat_rd,
    output logic             eof_o
);

    typedef struct packed {
        logic seen;
        logic flag;
    } eof_st_t;

    eof_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = framed & (eof_in | err_any | (st_q.seen & ~stat_rd));
        st_d.flag = framed & (st_d.seen | (eof_cnt != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eof_o = st_q.flag;

    assert_stored_eof_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (framed && eof_cnt != '0) |=> eof_o);

    assert_eof_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (framed && eof_in) |=> eof_o);

    assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (framed && stat_rd && !eof_in && !err_any && eof_cnt == '0) |=> !eof_o);

    assert_err_marks_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (framed && err_any) |=> eof_o);

    assert_unframed_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !framed |=> !eof_o);

endmodule

// File: rtl/rxq_err_sum.sv
module rxq_err_sum #(
    parameter int NUM_ERR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] err_in,
    input  logic               stat_rd,
    output logic               err_any_o,
    output logic               err_o
);

    typedef struct packed {
        logic [NUM_ERR-1:0] bits;
        logic               flag;
    } err_st_t;

    err_st_t            st_d, st_q;
    logic [NUM_ERR-1:0] bit_nxt;

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_err_bit
        assign bit_nxt[g] = err_in[g] | (st_q.bits[g] & ~stat_rd);
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = bit_nxt;
        st_d.flag = |bit_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_any_o = |err_in;
    assign err_o     = st_q.flag;

    assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_in != '0) |=> err_o);

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && err_in == '0) |=> !err_o);

    assert_err_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !stat_rd) |=> err_o);

endmodule

// File: rtl/rxq_status_flags.sv
module rxq_status_flags
    import rxq_status_pkg::*;
#(
    parameter int OCC_W   = 7,
    parameter int NUM_ERR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OCC_W-1:0]   occ_cnt,
    input  logic [OCC_W-1:0]   thr_lvl,
    input  logic [OCC_W-1:0]   gran_lvl,
    input  logic               eof_strobe,
    input  logic [OCC_W-1:0]   eof_stored,
    input  logic [NUM_ERR-1:0] err_strobe,
    input  logic               stat_rd,
    input  logic [1:0]         link_mode,
    input  logic               eof_irq_en,
    output logic               full_flag,
    output logic               ready_flag,
    output logic               eof_flag,
    output logic               err_flag,
    output logic               irq_req
);

    typedef struct packed {
        logic en;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    framed;
    logic    err_any;

    assign framed = is_framed(link_mode_t'(link_mode));

    rxq_fill_hyst #(.OCC_W(OCC_W)) i_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .occ     (occ_cnt),
        .thr     (thr_lvl),
        .gran    (gran_lvl),
        .full_o  (full_flag),
        .ready_o (ready_flag)
    );

    rxq_err_sum #(.NUM_ERR(NUM_ERR)) i_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_in    (err_strobe),
        .stat_rd   (stat_rd),
        .err_any_o (err_any),
        .err_o     (err_flag)
    );

    rxq_frame_end #(.OCC_W(OCC_W)) i_eof (
        .clk     (clk),
        .rst_n   (rst_n),
        .framed  (framed),
        .eof_in  (eof_strobe),
        .eof_cnt (eof_stored),
        .err_any (err_any),
        .stat_rd (stat_rd),
        .eof_o   (eof_flag)
    );

    always_comb begin
        st_d    = st_q;
        st_d.en = eof_irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req = full_flag | (eof_flag & st_q.en);

    assert_irq_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        full_flag |-> irq_req);

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_flag && !eof_flag) |-> !irq_req);

    assert_irq_eof_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_irq_en && framed && eof_strobe) |=> irq_req);

endmodule

// File: tb/test_rxq_status_flags.sv
module test_rxq_status_flags;

    localparam int OCC_W   = 7;
    localparam int NUM_ERR = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [OCC_W-1:0]   occ_cnt = '0;
    logic [OCC_W-1:0]   thr_lvl = '0;
    logic [OCC_W-1:0]   gran_lvl = '0;
    logic               eof_strobe = 1'b0;
    logic [OCC_W-1:0]   eof_stored = '0;
    logic [NUM_ERR-1:0] err_strobe = '0;
    logic               stat_rd = 1'b0;
    logic [1:0]         link_mode = 2'd0;
    logic               eof_irq_en = 1'b0;
    logic               full_flag, ready_flag, eof_flag, err_flag, irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rxq_status_flags #(.OCC_W(OCC_W), .NUM_ERR(NUM_ERR)) i_rxq_status_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .occ_cnt    (occ_cnt),
        .thr_lvl    (thr_lvl),
        .gran_lvl   (gran_lvl),
        .eof_strobe (eof_strobe),
        .eof_stored (eof_stored),
        .err_strobe (err_strobe),
        .stat_rd    (stat_rd),
        .link_mode  (link_mode),
        .eof_irq_en (eof_irq_en),
        .full_flag  (full_flag),
        .ready_flag (ready_flag),
        .eof_flag   (eof_flag),
        .err_flag   (err_flag),
        .irq_req    (irq_req)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    // one rising edge passes; sample on the following falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        eof_strobe = 1'b0;
        err_strobe = '0;
        stat_rd    = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        occ_cnt = 7'd50; eof_stored = 7'd3; link_mode = 2'd3; eof_irq_en = 1'b1;
        err_strobe = 4'b1111; eof_strobe = 1'b1;
        repeat (3) step();
        check(full_flag, 1'b0, "R1", "full in reset");
        check(ready_flag, 1'b0, "R1", "ready in reset");
        check(eof_flag, 1'b0, "R1", "eof in reset");
        check(err_flag, 1'b0, "R1", "err in reset");
        check(irq_req, 1'b0, "R1", "irq in reset");
        occ_cnt = '0; eof_stored = '0; link_mode = 2'd0; eof_irq_en = 1'b0;
        clear_strobes();
        rst_n = 1'b1;
        step();
        check(full_flag | ready_flag | eof_flag | err_flag | irq_req, 1'b0, "R1", "outputs after reset");
    endtask

    task automatic t_full_hyst();
        link_mode = 2'd0; thr_lvl = 7'd40; gran_lvl = 7'd10;
        occ_cnt = 7'd40; step();
        check(full_flag, 1'b0, "R2", "occ equal to threshold");
        occ_cnt = 7'd41; step();
        check(full_flag, 1'b1, "R2", "occ above threshold");
        check(irq_req, 1'b1, "R10", "irq follows full");
        occ_cnt = 7'd20; step();
        check(full_flag, 1'b1, "R3", "occ inside band");
        occ_cnt = 7'd10; step();
        check(full_flag, 1'b1, "R3", "occ equal to drain level");
        occ_cnt = 7'd9; step();
        check(full_flag, 1'b0, "R3", "occ below drain level");
        check(irq_req, 1'b0, "R10", "irq follows full low");
        occ_cnt = 7'd30; step();
        check(full_flag, 1'b0, "R3", "rising inside band does not set");
        occ_cnt = '0; step();
    endtask

    task automatic t_ready();
        occ_cnt = '0; step();
        check(ready_flag, 1'b0, "R4", "empty");
        occ_cnt = 7'd1; step();
        check(ready_flag, 1'b1, "R4", "one entry");
        occ_cnt = 7'd64; step();
        check(ready_flag, 1'b1, "R4", "many entries");
        occ_cnt = '0; step();
        check(ready_flag, 1'b0, "R4", "drained");
    endtask

    task automatic t_eof_sticky();
        link_mode = 2'd3; eof_stored = '0;
        stat_rd = 1'b1; step(); clear_strobes();
        eof_strobe = 1'b1; step(); clear_strobes();
        check(eof_flag, 1'b1, "R6", "eof strobe latched");
        step();
        check(eof_flag, 1'b1, "R6", "eof held without read");
        stat_rd = 1'b1; step(); clear_strobes();
        check(eof_flag, 1'b0, "R6", "status read clears");
        eof_strobe = 1'b1; step(); clear_strobes();
        stat_rd = 1'b1; eof_strobe = 1'b1; step(); clear_strobes();
        step();
        check(eof_flag, 1'b1, "R6", "read with same-cycle eof keeps");
        stat_rd = 1'b1; step(); clear_strobes();
        check(eof_flag, 1'b0, "R6", "second read clears");
    endtask

    task automatic t_eof_stored();
        link_mode = 2'd2; eof_stored = 7'd2; step();
        check(eof_flag, 1'b1, "R5", "stored marks set flag");
        stat_rd = 1'b1; step(); clear_strobes();
        check(eof_flag, 1'b1, "R5", "read does not clear while stored");
        eof_stored = '0; step();
        check(eof_flag, 1'b0, "R5", "flag drops when none stored");
    endtask

    task automatic t_err_eof();
        link_mode = 2'd3;
        err_strobe = 4'b0010; step(); clear_strobes();
        check(eof_flag, 1'b1, "R7", "error marks end of frame");
        check(err_flag, 1'b1, "R9", "error flag from bit 1");
        stat_rd = 1'b1; step(); clear_strobes();
        check(eof_flag, 1'b0, "R7", "read clears error-forced eof");
        check(err_flag, 1'b0, "R9", "read clears errors");
    endtask

    task automatic t_unframed();
        link_mode = 2'd0; eof_stored = 7'd3; eof_strobe = 1'b1; step(); clear_strobes();
        check(eof_flag, 1'b0, "R8", "mode 0 eof reads zero");
        link_mode = 2'd1; eof_strobe = 1'b1; step(); clear_strobes();
        check(eof_flag, 1'b0, "R8", "mode 1 eof reads zero");
        eof_stored = '0; link_mode = 2'd2; step();
        check(eof_flag, 1'b0, "R8", "no sticky left from unframed");
    endtask

    task automatic t_err_sum();
        link_mode = 2'd0;
        err_strobe = 4'b1000; step(); clear_strobes();
        check(err_flag, 1'b1, "R9", "bit 3 sets error");
        step();
        check(err_flag, 1'b1, "R9", "error sticky");
        stat_rd = 1'b1; err_strobe = 4'b0001; step(); clear_strobes();
        check(err_flag, 1'b1, "R9", "same-cycle strobe survives read");
        stat_rd = 1'b1; step(); clear_strobes();
        check(err_flag, 1'b0, "R9", "read clears all");
    endtask

    task automatic t_irq();
        link_mode = 2'd3; thr_lvl = 7'd40; gran_lvl = 7'd10; occ_cnt = 7'd5;
        eof_stored = '0; eof_irq_en = 1'b1; step();
        eof_strobe = 1'b1; step(); clear_strobes();
        check(full_flag, 1'b0, "R10", "below threshold");
        check(irq_req, 1'b1, "R10", "eof forces irq");
        eof_irq_en = 1'b0; step();
        check(irq_req, 1'b0, "R10", "enable off irq follows full");
        check(eof_flag, 1'b1, "R10", "eof still set");
        stat_rd = 1'b1; step(); clear_strobes();
        occ_cnt = '0; step();
    endtask

    initial begin
        step();
        t_reset();
        t_full_hyst();
        t_ready();
        t_eof_sticky();
        t_eof_stored();
        t_err_eof();
        t_unframed();
        t_err_sum();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule